// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier

This block sits on the device side of a parallel flash interface, between the asynchronous control pins and the command state machine. It samples the active-low chip enable, write enable and output enable pins, plus a supply-good indicator, through two-flop synchronizers. Each synchronized pin then passes a pulse-width filter. The block turns a properly framed write into one clean commit strobe that carries the address and data seen on the bus during the write.

A write counts only when write enable returns high after a low phase in which chip enable was low and output enable was high. Short pulses on any control pin are discarded. While the supply is below the lockout level, every write is dropped and the downstream command logic is held in read mode.

After the supply becomes good, the first write-enable rising edge is refused if the pins were already sitting in the write state at that moment. Normal operation resumes once write enable or chip enable has been seen high.

Top module: `flash_wr_qualifier`

## Requirements
- R1: While `rstN` is low, `wrCommit` is 0 and `readModeHold` is 1.
- R2: A filtered rising edge of `weN` commits a write only if the filtered pins in the cycle before the edge showed `ceN`=0, `weN`=0 and `oeN`=1, and the supply was good. `wrCommit` is then high for exactly one clock, FILT_CYC+3 clock edges after the edge is first sampled.
- R3: A `weN` rise with `oeN` low during the low phase commits nothing.
- R4: A `weN` pulse with `ceN` high commits nothing.
- R5: A level held on any control pin for fewer than FILT_CYC clocks after synchronization is ignored. A `weN` low pulse that short commits nothing, and a chip-enable blip that short does not break an ongoing write.
- R6: `wrAddr` and `wrData` carry the bus value from the last clock in which the synchronized pins were in the write state. The bus must be held for two clocks after `weN` rises.
- R7: `readModeHold` follows the filtered supply indicator inverted. While it is 1, no write commits.
- R8: If the filtered pins are in the write state in the cycle the filtered supply becomes good, the next qualified `weN` rising edge commits nothing.
- R9: The suppression from R8 ends once filtered `weN` or `ceN` is high, so the next properly framed write commits.
- R10: `wrAddr` and `wrData` change only in the cycle in which `wrCommit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable pin, active low |
| weN | input | 1 | Write enable pin, active low |
| oeN | input | 1 | Output enable pin, active low |
| supplyOk | input | 1 | 1 when supply is above the lockout level |
| addrIn | input | ADDR_W | Address bus |
| dataIn | input | DATA_W | Data bus |
| wrCommit | output | 1 | One-clock write commit strobe |
| wrAddr | output | ADDR_W | Address of the committed write |
| wrData | output | DATA_W | Data of the committed write |
| readModeHold | output | 1 | Holds the command logic in read mode |

## Verification
A filter count that is off by one shows at the ports within a single write. The commit strobe moves by a clock, or a pulse of FILT_CYC-1 clocks gets through as a write. A stale power-up block is just as visible: either the first write after supply recovery is swallowed when the pins were idle, or a write is accepted when the pins were already in the write state. Either case is caught on the next write-enable edge. A capture enable that lags or leads the pins leaves the wrong bus word on `wrAddr` in the cycle `wrCommit` rises.

// File: rtl/flash_wq_pkg.sv
package flash_wq_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;  // bus sample enable while pins are in write state
    logic commit;   // qualified write edge accepted
  } wqStrobe_t;

  localparam int PIN_CE  = 0;
  localparam int PIN_WE  = 1;
  localparam int PIN_OE  = 2;
  localparam int PIN_SUP = 3;
  localparam int NUM_PINS = 4;
endpackage

// File: rtl/wq_pin_filter.sv
module wq_pin_filter #(
  parameter int   FILT_CYC = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic syncOut,
  output logic filtOut
);
  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);

  logic syncA, syncB, filtQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= RST_VAL;
      syncB  <= RST_VAL;
      filtQ  <= RST_VAL;
      runCnt <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      if (syncB == filtQ) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_CYC - 1)) begin
        filtQ  <= syncB;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign syncOut = syncB;
  assign filtOut = filtQ;

  // R5: the filtered level only moves to a value the synchronizer already held
  p_min_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    (filtQ != $past(filtQ)) |-> ($past(syncB) == filtQ));
endmodule

// File: rtl/wq_ctrl.sv
module wq_ctrl
  import flash_wq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceF,
  input  logic      weF,
  input  logic      oeF,
  input  logic      supF,
  input  logic      ceS,
  input  logic      weS,
  input  logic      oeS,
  output wqStrobe_t strobe,
  output logic      readModeHold
);
  logic wePrev, armPrev, supPrev, puBlock;
  logic armNow, weRise;

  assign armNow = !ceF && !weF && oeF;
  assign weRise = !wePrev && weF && armPrev;

  always_comb begin
    strobe         = '0;
    strobe.capture = !ceS && !weS && oeS;
    strobe.commit  = weRise && supF && !puBlock;
  end

  assign readModeHold = !supF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wePrev  <= 1'b1;
      armPrev <= 1'b0;
      supPrev <= 1'b0;
      puBlock <= 1'b0;
    end else begin
      wePrev  <= weF;
      armPrev <= armNow;
      supPrev <= supF;
      if (supF && !supPrev && armNow)
        puBlock <= 1'b1;   // pins already in write state at power-up (R8)
      else if (weF || ceF)
        puBlock <= 1'b0;   // released once WE or CE seen high (R9)
    end
  end

  // R8: an edge seen while the power-up block is set never commits
  p_pu_swallow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (puBlock && !wePrev && weF) |-> !strobe.commit);

  // R7: no commit request while supply is low
  p_lockout_ctrl_r7: assert property (@(posedge clk) disable iff (!rstN)
    readModeHold |-> !strobe.commit);
endmodule

// File: rtl/wq_datapath.sv
module wq_datapath
  import flash_wq_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wqStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wrCommit,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  logic [ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAddr <= '0;
      holdData <= '0;
      wrAddr   <= '0;
      wrData   <= '0;
      wrCommit <= 1'b0;
    end else begin
      if (strobe.capture) begin
        holdAddr <= addrIn;
        holdData <= dataIn;
      end
      wrCommit <= strobe.commit;
      if (strobe.commit) begin
        wrAddr <= holdAddr;
        wrData <= holdData;
      end
    end
  end

  // R10: outputs hold between commits
  p_out_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrCommit |-> ($stable(wrAddr) && $stable(wrData)));
endmodule

// File: rtl/flash_wr_qualifier.sv
module flash_wr_qualifier
  import flash_wq_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int FILT_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              supplyOk,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wrCommit,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              readModeHold
);
  // control pins reset to idle-high, supply to "not good"
  localparam logic [NUM_PINS-1:0] PIN_RST = 4'b0111;

  logic [NUM_PINS-1:0] pinRaw, pinSync, pinFilt;
  wqStrobe_t strobe;

  assign pinRaw = {supplyOk, oeN, weN, ceN};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    wq_pin_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(PIN_RST[i])) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (pinRaw[i]),
      .syncOut(pinSync[i]),
      .filtOut(pinFilt[i])
    );
  end

  wq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ceF         (pinFilt[PIN_CE]),
    .weF         (pinFilt[PIN_WE]),
    .oeF         (pinFilt[PIN_OE]),
    .supF        (pinFilt[PIN_SUP]),
    .ceS         (pinSync[PIN_CE]),
    .weS         (pinSync[PIN_WE]),
    .oeS         (pinSync[PIN_OE]),
    .strobe      (strobe),
    .readModeHold(readModeHold)
  );

  wq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .wrCommit(wrCommit),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

  // R2: the commit strobe is never wider than one clock
  p_commit_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  // R7: lockout blocks the strobe one clock later
  p_lockout_r7: assert property (@(posedge clk) disable iff (!rstN)
    readModeHold |=> !wrCommit);
endmodule

// File: tb/tb_flash_wr_qualifier.sv
module tb_flash_wr_qualifier;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int F  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, supplyOk = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic wrCommit, readModeHold;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;

  // stimulus variables applied at each falling edge
  logic vRst = 1'b0, vCe = 1'b1, vWe = 1'b1, vOe = 1'b1, vSup = 1'b1;
  logic [AW-1:0] vAddr = '0;
  logic [DW-1:0] vData = '0;

  int checks = 0, errors = 0, commits = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  flash_wr_qualifier #(.ADDR_W(AW), .DATA_W(DW), .FILT_CYC(F)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .supplyOk(supplyOk), .addrIn(addrIn), .dataIn(dataIn),
    .wrCommit(wrCommit), .wrAddr(wrAddr), .wrData(wrData),
    .readModeHold(readModeHold));

  // ---------------- behavioural reference model ----------------
  int s1[4], s2[4], flt[4], run[4];
  int wePrev, armPrev, supPrev, puBlk;
  logic [AW-1:0] hA, oA;
  logic [DW-1:0] hD, oD;
  int oC;

  function automatic int rstVal(int i);
    return (i == 3) ? 0 : 1;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin
      s1[i] = rstVal(i); s2[i] = rstVal(i); flt[i] = rstVal(i); run[i] = 0;
    end
    wePrev = 1; armPrev = 0; supPrev = 0; puBlk = 0;
    hA = '0; hD = '0; oA = '0; oD = '0; oC = 0;
  endtask

  task automatic modelStep();
    int pin[4];
    int arm, rise, com, cap;
    pin[0] = ceN; pin[1] = weN; pin[2] = oeN; pin[3] = supplyOk;
    if (!rstN) begin
      modelReset();
      return;
    end
    arm  = (!flt[0] && !flt[1] && flt[2]) ? 1 : 0;
    rise = (!wePrev && flt[1] && armPrev) ? 1 : 0;
    com  = (rise && flt[3] && !puBlk) ? 1 : 0;
    cap  = (!s2[0] && !s2[1] && s2[2]) ? 1 : 0;
    oC = com;
    if (com != 0) begin oA = hA; oD = hD; end
    if (cap != 0) begin hA = addrIn; hD = dataIn; end
    if (flt[3] && !supPrev && arm) puBlk = 1;
    else if (flt[1] || flt[0]) puBlk = 0;
    wePrev = flt[1]; armPrev = arm; supPrev = flt[3];
    for (int i = 0; i < 4; i++) begin
      if (s2[i] == flt[i]) run[i] = 0;
      else if (run[i] == F - 1) begin flt[i] = s2[i]; run[i] = 0; end
      else run[i]++;
      s2[i] = s1[i];
      s1[i] = pin[i];
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: compare, apply next inputs, advance model
  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R2 wrCommit", 64'(wrCommit), 64'(oC));
      chk("R6 wrAddr", 64'(wrAddr), 64'(oA));
      chk("R6 wrData", 64'(wrData), 64'(oD));
      chk("R7 readModeHold", 64'(readModeHold), 64'(!flt[3]));
      if (wrCommit) commits++;
      rstN = vRst; ceN = vCe; weN = vWe; oeN = vOe; supplyOk = vSup;
      addrIn = vAddr; dataIn = vData;
      modelStep();
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic oe, input logic ce, input int lowLen);
    vAddr = a; vData = d; vCe = ce; vOe = oe; cyc(1);
    vWe = 1'b0; cyc(lowLen);
    vWe = 1'b1; cyc(4);
    vCe = 1'b1; vOe = 1'b1; vAddr = ~a; vData = ~d;
    cyc(F + 6);
  endtask

  int base;

  initial begin
    modelReset();
    cyc(4);
    // R1: reset state
    chk("R1 commit in reset", 64'(wrCommit), 64'd0);
    chk("R1 hold in reset", 64'(readModeHold), 64'd1);
    vRst = 1'b1; cyc(F + 6);
    chk("R7 released with good supply", 64'(readModeHold), 64'd0);

    // R2/R6: several plain writes
    base = commits;
    doWrite(21'h0_0555, 16'h00AA, 1'b1, 1'b0, 6);
    chk("R2 one commit", 64'(commits - base), 64'd1);
    chk("R6 address", 64'(wrAddr), 64'h0_0555);
    chk("R6 data", 64'(wrData), 64'h00AA);
    for (int w = 0; w < 3; w++) begin
      base = commits;
      doWrite(AW'(21'h1A000 + w * 37), DW'(16'h1234 ^ (w * 16'h0F0F)), 1'b1, 1'b0, 4 + w);
      chk("R2 commit per write", 64'(commits - base), 64'd1);
      chk("R6 data per write", 64'(wrData), 64'(DW'(16'h1234 ^ (w * 16'h0F0F))));
    end

    // R3: output enable low
    base = commits;
    doWrite(21'h00111, 16'h1111, 1'b0, 1'b0, 6);
    chk("R3 no commit with OE low", 64'(commits - base), 64'd0);
    // R4: chip enable high
    doWrite(21'h00222, 16'h2222, 1'b1, 1'b1, 6);
    chk("R4 no commit with CE high", 64'(commits - base), 64'd0);
    // R10: outputs unchanged
    chk("R10 address held", 64'(wrAddr), 64'(AW'(21'h1A000 + 2 * 37)));

    // R5: short WE pulse
    doWrite(21'h00333, 16'h3333, 1'b1, 1'b0, F - 1);
    chk("R5 short WE pulse ignored", 64'(commits - base), 64'd0);
    // R5: short CE blip during a write
    vAddr = 21'h00444; vData = 16'h4444; vCe = 1'b0; cyc(1);
    vWe = 1'b0; cyc(3);
    vCe = 1'b1; cyc(F - 1);
    vCe = 1'b0; cyc(F + 4);
    vWe = 1'b1; cyc(4);
    vCe = 1'b1; cyc(F + 6);
    chk("R5 CE blip keeps write", 64'(commits - base), 64'd1);
    chk("R5 blip write address", 64'(wrAddr), 64'h00444);

    // R7: lockout
    vSup = 1'b0; cyc(F + 4);
    chk("R7 hold during low supply", 64'(readModeHold), 64'd1);
    base = commits;
    doWrite(21'h00666, 16'h6666, 1'b1, 1'b0, 6);
    chk("R7 write ignored in lockout", 64'(commits - base), 64'd0);

    // R8: power-up with pins in write state
    vCe = 1'b0; vWe = 1'b0; vOe = 1'b1; vAddr = 21'h00777; cyc(F + 4);
    vSup = 1'b1; cyc(F + 6);
    chk("R8 hold released", 64'(readModeHold), 64'd0);
    vWe = 1'b1; cyc(4);
    vCe = 1'b1; cyc(F + 6);
    chk("R8 first edge swallowed", 64'(commits - base), 64'd0);
    // R9: next framed write accepted
    doWrite(21'h00888, 16'h8888, 1'b1, 1'b0, 6);
    chk("R9 write accepted after release", 64'(commits - base), 64'd1);
    chk("R9 address", 64'(wrAddr), 64'h00888);

    // R8 counterpart: idle pins at power-up do not block
    vSup = 1'b0; cyc(F + 4);
    vSup = 1'b1; cyc(F + 6);
    base = commits;
    doWrite(21'h00999, 16'h9999, 1'b1, 1'b0, 6);
    chk("R8 idle power-up not blocked", 64'(commits - base), 64'd1);

    // R1: reset mid-run
    vRst = 1'b0; cyc(3);
    chk("R1 outputs cleared", 64'(wrAddr), 64'd0);
    chk("R1 hold asserted", 64'(readModeHold), 64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule